// File: doc/BRIEF.md
# Pin Vector Drive/Compare Engine

This block turns one test vector per clock cycle into drive and compare actions for a group of tester pins. Every pin gets a 4-bit state code for the vector. The code either enables the pin driver with a data bit, or checks two digitized comparator readings: "above the high threshold" and "below the low threshold". The result is a per-pin fail flag for each vector. A sticky per-pin fail record collects those flags, and a global fail flag is the OR of the record.

A pin may take its drive bit or its expected bit from a source word. The source word arrives over a valid/ready handshake. Bits from pins in the either-valid state can be pushed to a capture output. A repeat code reuses a pin's previous resolved state. A separate repeat code reuses the previous time-set index, and the resolved index is output with the vector. A match/fail status record for each vector is emitted a fixed number of cycles after the vector, through a delay line.

Top module: `pve_engine`

## Requirements
- R1: Code 0x0 drives 0 and code 0x1 drives 1. Both set the pin's drive enable in the cycle after the vector and never flag a fail.
- R2: Code 0x2 (expect low) passes only when the below-low reading is 1 and the above-high reading is 0. Code 0x3 (expect high) passes only when the above-high reading is 1 and the below-low reading is 0. The driver stays off for both.
- R3: Code 0x4 turns the driver off and masks the compare: no fail for any comparator reading.
- R4: Code 0x5 (midband) passes only when both comparator readings are 0.
- R5: Code 0x6 (either-valid) passes when exactly one comparator reading is 1. With the capture enable set, a vector holding any 0x6 pin raises the capture valid output, and each such pin's above-high reading appears on its capture data bit. Other pins read 0.
- R6: Code 0x7 drives the pin's bit of the source word. Code 0x8 compares against that bit: expect high when it is 1 and expect low when it is 0. A source word is requested (ready high) only when the vector holds a pin whose resolved state is 0x7 or 0x8.
- R7: Code 0x9 reuses the pin's previous resolved state. On a pin with no earlier vector since reset, it acts as 0x4 and sets the sticky repeat error flag.
- R8: Time-set indices 0 to 30 pass straight to the time-set output. Index 31 reuses the previous resolved index. With no earlier vector since reset, index 31 resolves to 0 and sets the sticky repeat error flag.
- R9: The status record of a vector (valid, match, per-pin fail) appears exactly LATENCY cycles after the per-pin result of that vector (default 80). Match means no pin of that vector failed.
- R10: Codes 0xA to 0xF act as 0x4, are remembered as 0x4 for a later repeat, and set the sticky illegal-code flag.
- R11: The per-pin fail record and the error flags hold until the synchronous clear input. A fail or error event in the clearing cycle is still recorded. The global fail output is the OR of the record.
- R12: If a pin needs source data while the source valid input is low, the pin acts as 0x4 and the sticky underflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of fail record and error flags |
| vec_valid | input | 1 | A vector is presented this cycle |
| vec_codes | input | 4*NPINS | State codes, pin p in bits 4p+3..4p |
| vec_tset | input | TSET_W | Time-set index, all ones repeats |
| cmp_hi | input | NPINS | Pin reads above the high threshold |
| cmp_lo | input | NPINS | Pin reads below the low threshold |
| cap_en | input | 1 | Capture enable for either-valid pins |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Vector consumes a source word |
| src_data | input | NPINS | Source word, one bit per pin |
| drv_en | output | NPINS | Driver enable per pin |
| drv_data | output | NPINS | Drive data per pin |
| tset_out | output | TSET_W | Resolved time-set index |
| vec_out_valid | output | 1 | Per-vector outputs hold a result |
| pin_fail | output | NPINS | Per-pin fail of the last vector |
| cap_valid | output | 1 | Capture word valid |
| cap_data | output | NPINS | Captured comparator bits |
| status_valid | output | 1 | Delayed status record valid |
| status_match | output | 1 | Delayed vector matched |
| status_fail | output | NPINS | Delayed per-pin fail |
| fail_sticky | output | NPINS | Sticky per-pin fail record |
| any_fail | output | 1 | OR of the sticky record |
| err_repeat | output | 1 | Sticky repeat-without-history flag |
| err_illegal | output | 1 | Sticky illegal-code flag |
| err_underflow | output | 1 | Sticky source underflow flag |

## Verification
On every cycle, the assertions check the following: a driven pin never fails; a masked or illegal pin never drives or fails; a first-time repeat stays inert; an underflow raises its flag; a literal time set is passed through; the fail record only grows between clears. The exact pass/fail truth of each compare state over all comparator readings, the source bit used by drive and expect states, repeat chains, capture contents and the exact status delay can only be shown by the bench's sweeps and directed sequences.

// File: rtl/pve_pkg.sv
// Shared constants, types and the pin state evaluator for the vector engine.
// Assumes a 4-bit pin code; codes above PC_REPEAT are illegal.
package pve_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] PC_ZERO   = 4'h0;
    localparam logic [CODE_W-1:0] PC_ONE    = 4'h1;
    localparam logic [CODE_W-1:0] PC_LOW    = 4'h2;
    localparam logic [CODE_W-1:0] PC_HIGH   = 4'h3;
    localparam logic [CODE_W-1:0] PC_OFF    = 4'h4;
    localparam logic [CODE_W-1:0] PC_MID    = 4'h5;
    localparam logic [CODE_W-1:0] PC_EITHER = 4'h6;
    localparam logic [CODE_W-1:0] PC_SRCDRV = 4'h7;
    localparam logic [CODE_W-1:0] PC_SRCEXP = 4'h8;
    localparam logic [CODE_W-1:0] PC_REPEAT = 4'h9;

    typedef struct packed {
        logic drv_en;
        logic drv_val;
        logic fail;
        logic cap;
    } pin_eval_t;

    // True for codes that carry a defined meaning.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return c <= PC_REPEAT;
    endfunction

    // True when the state draws on the source word.
    function automatic logic code_uses_src(input logic [CODE_W-1:0] c);
        return (c == PC_SRCDRV) || (c == PC_SRCEXP);
    endfunction

    // Turns a resolved (non-repeat) state into drive/compare actions.
    function automatic pin_eval_t eval_state(input logic [CODE_W-1:0] st,
                                             input logic hi,
                                             input logic lo,
                                             input logic sbit);
        pin_eval_t e;
        e = '0;
        case (st)
            PC_ZERO:   begin e.drv_en = 1'b1; e.drv_val = 1'b0; end
            PC_ONE:    begin e.drv_en = 1'b1; e.drv_val = 1'b1; end
            PC_LOW:    e.fail = !(lo && !hi);
            PC_HIGH:   e.fail = !(hi && !lo);
            PC_MID:    e.fail = hi || lo;
            PC_EITHER: begin e.fail = !(hi ^ lo); e.cap = 1'b1; end
            PC_SRCDRV: begin e.drv_en = 1'b1; e.drv_val = sbit; end
            PC_SRCEXP: e.fail = sbit ? !(hi && !lo) : !(lo && !hi);
            default:   e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pve_pin_cell.sv
// One pin lane: resolves repeat and illegal codes against the lane's own
// history, then evaluates drive/compare for the vector. All outputs are
// combinational for the current vector. Assumes the caller gates the
// source availability into src_ok for the whole vector.
module pve_pin_cell
    import pve_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [CODE_W-1:0] code_in,
    input  logic              src_bit,
    input  logic              src_ok,
    input  logic              cmp_hi,
    input  logic              cmp_lo,
    output logic              needs_src,
    output logic              rep_err,
    output logic              illegal,
    output logic              drv_en,
    output logic              drv_val,
    output logic              fail,
    output logic              cap_hit
);

    logic [CODE_W-1:0] hist_q;
    logic              hist_vld_q;
    logic [CODE_W-1:0] res;
    logic [CODE_W-1:0] eff;
    pin_eval_t         ev;

    // Resolve the code against history and source availability.
    always_comb begin
        illegal = vec_valid && !code_legal(code_in);
        rep_err = vec_valid && (code_in == PC_REPEAT) && !hist_vld_q;
        if (code_in == PC_REPEAT) begin
            res = hist_vld_q ? hist_q : PC_OFF;
        end else if (!code_legal(code_in)) begin
            res = PC_OFF;
        end else begin
            res = code_in;
        end
        needs_src = vec_valid && code_uses_src(res);
        eff       = (needs_src && !src_ok) ? PC_OFF : res;
        ev        = eval_state(eff, cmp_hi, cmp_lo, src_bit);
        drv_en    = vec_valid && ev.drv_en;
        drv_val   = ev.drv_val;
        fail      = vec_valid && ev.fail;
        cap_hit   = vec_valid && ev.cap;
    end

    // Remember the resolved state (before underflow masking) per vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q     <= PC_OFF;
            hist_vld_q <= 1'b0;
        end else if (vec_valid) begin
            hist_q     <= res;
            hist_vld_q <= 1'b1;
        end
    end

    p_rep_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && code_in == PC_REPEAT && !hist_vld_q |-> !drv_en && !fail);

    p_illegal_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && code_in > PC_REPEAT |-> !drv_en && !fail && !needs_src);

    p_mid_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && code_in == PC_MID && !cmp_hi && !cmp_lo |-> !fail);

endmodule

// File: rtl/pve_tset.sv
// Time-set resolver: passes literal indices through and replaces the
// all-ones repeat code with the last resolved index. Assumes one vector
// per cycle when vec_valid is high.
module pve_tset #(
    parameter int TSET_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [TSET_W-1:0] tset_in,
    output logic [TSET_W-1:0] tset_res,
    output logic              rep_err
);

    localparam logic [TSET_W-1:0] TS_REPEAT = {TSET_W{1'b1}};

    logic [TSET_W-1:0] hist_q;
    logic              hist_vld_q;

    // Pick the literal index or the remembered one.
    always_comb begin
        if (tset_in == TS_REPEAT) begin
            tset_res = hist_vld_q ? hist_q : '0;
        end else begin
            tset_res = tset_in;
        end
        rep_err = vec_valid && (tset_in == TS_REPEAT) && !hist_vld_q;
    end

    // Track the last resolved index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q     <= '0;
            hist_vld_q <= 1'b0;
        end else if (vec_valid) begin
            hist_q     <= tset_res;
            hist_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pve_delay.sv
// Fixed-depth delay line: the word entering on one edge leaves DEPTH
// edges later. Assumes DEPTH >= 1; cleared by reset.
module pve_delay #(
    parameter int WIDTH = 6,
    parameter int DEPTH = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [DEPTH];

    // First stage loads the input word.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= din;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        // Each later stage copies its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/pve_engine.sv
// Vector drive/compare engine for NPINS pins. Per-vector results are
// registered one cycle after the vector; the status record follows
// LATENCY cycles later. Assumes comparator readings belong to the vector
// presented in the same cycle.
module pve_engine
    import pve_pkg::*;
#(
    parameter int NPINS   = 4,
    parameter int TSET_W  = 5,
    parameter int LATENCY = 80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    vec_valid,
    input  logic [NPINS*CODE_W-1:0] vec_codes,
    input  logic [TSET_W-1:0]       vec_tset,
    input  logic [NPINS-1:0]        cmp_hi,
    input  logic [NPINS-1:0]        cmp_lo,
    input  logic                    cap_en,
    input  logic                    src_valid,
    output logic                    src_ready,
    input  logic [NPINS-1:0]        src_data,
    output logic [NPINS-1:0]        drv_en,
    output logic [NPINS-1:0]        drv_data,
    output logic [TSET_W-1:0]       tset_out,
    output logic                    vec_out_valid,
    output logic [NPINS-1:0]        pin_fail,
    output logic                    cap_valid,
    output logic [NPINS-1:0]        cap_data,
    output logic                    status_valid,
    output logic                    status_match,
    output logic [NPINS-1:0]        status_fail,
    output logic [NPINS-1:0]        fail_sticky,
    output logic                    any_fail,
    output logic                    err_repeat,
    output logic                    err_illegal,
    output logic                    err_underflow
);

    localparam int STAT_W = NPINS + 2;
    localparam logic [TSET_W-1:0] TS_REPEAT = {TSET_W{1'b1}};

    logic [NPINS-1:0]  c_needs_src, c_rep_err, c_illegal;
    logic [NPINS-1:0]  c_drv_en, c_drv_val, c_fail, c_cap_hit;
    logic [TSET_W-1:0] ts_res;
    logic              ts_rep_err;
    logic              ev_underflow;
    logic [STAT_W-1:0] stat_in, stat_out;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pve_pin_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .vec_valid (vec_valid),
            .code_in   (vec_codes[p*CODE_W +: CODE_W]),
            .src_bit   (src_data[p]),
            .src_ok    (src_valid),
            .cmp_hi    (cmp_hi[p]),
            .cmp_lo    (cmp_lo[p]),
            .needs_src (c_needs_src[p]),
            .rep_err   (c_rep_err[p]),
            .illegal   (c_illegal[p]),
            .drv_en    (c_drv_en[p]),
            .drv_val   (c_drv_val[p]),
            .fail      (c_fail[p]),
            .cap_hit   (c_cap_hit[p])
        );
    end

    pve_tset #(.TSET_W(TSET_W)) u_tset (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_valid (vec_valid),
        .tset_in   (vec_tset),
        .tset_res  (ts_res),
        .rep_err   (ts_rep_err)
    );

    // Request a source word whenever any pin resolves to a source state.
    always_comb begin
        src_ready    = |c_needs_src;
        ev_underflow = src_ready && !src_valid;
    end

    // Register the per-vector drive, compare and capture results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_en        <= '0;
            drv_data      <= '0;
            tset_out      <= '0;
            vec_out_valid <= 1'b0;
            pin_fail      <= '0;
            cap_valid     <= 1'b0;
            cap_data      <= '0;
        end else begin
            drv_en        <= c_drv_en;
            drv_data      <= c_drv_val & c_drv_en;
            vec_out_valid <= vec_valid;
            pin_fail      <= c_fail;
            cap_valid     <= cap_en && (|c_cap_hit);
            cap_data      <= cap_en ? (c_cap_hit & cmp_hi) : '0;
            if (vec_valid) tset_out <= ts_res;
        end
    end

    // Accumulate fails and error events until a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_sticky   <= '0;
            err_repeat    <= 1'b0;
            err_illegal   <= 1'b0;
            err_underflow <= 1'b0;
        end else if (clr) begin
            fail_sticky   <= c_fail;
            err_repeat    <= (|c_rep_err) || ts_rep_err;
            err_illegal   <= |c_illegal;
            err_underflow <= ev_underflow;
        end else begin
            fail_sticky   <= fail_sticky | c_fail;
            err_repeat    <= err_repeat || (|c_rep_err) || ts_rep_err;
            err_illegal   <= err_illegal || (|c_illegal);
            err_underflow <= err_underflow || ev_underflow;
        end
    end

    // Global fail is the OR of the sticky record.
    assign any_fail = |fail_sticky;

    // Pack the registered result into the status delay line.
    always_comb begin
        stat_in = {vec_out_valid, vec_out_valid && !(|pin_fail), pin_fail};
    end

    pve_delay #(.WIDTH(STAT_W), .DEPTH(LATENCY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (stat_in),
        .dout  (stat_out)
    );

    assign status_valid = stat_out[STAT_W-1];
    assign status_match = stat_out[STAT_W-2];
    assign status_fail  = stat_out[NPINS-1:0];

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        p_drive_nofail_r1: assert property (@(posedge clk) disable iff (!rst_n)
            drv_en[p] |-> !pin_fail[p]);

        p_xmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vec_valid && vec_codes[p*CODE_W +: CODE_W] == PC_OFF
            |=> !pin_fail[p] && !drv_en[p]);

        p_expect_nodrive_r2: assert property (@(posedge clk) disable iff (!rst_n)
            vec_valid && (vec_codes[p*CODE_W +: CODE_W] == PC_LOW ||
                          vec_codes[p*CODE_W +: CODE_W] == PC_HIGH)
            |=> !drv_en[p]);
    end

    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (fail_sticky & $past(fail_sticky)) == $past(fail_sticky));

    p_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready && !src_valid |=> err_underflow);

    p_tset_literal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_tset != TS_REPEAT |=> tset_out == $past(vec_tset));

    p_match_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_match |-> status_valid);

    p_capture_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(cap_en));

endmodule

// File: tb/test_pve_engine.sv
`timescale 1ns/1ps
module test_pve_engine;

    localparam int NP  = 4;
    localparam int TW  = 5;
    localparam int LAT = 80;

    logic          clk = 1'b0;
    logic          rst_n, clr, vec_valid, cap_en, src_valid;
    logic [NP*4-1:0] vec_codes;
    logic [TW-1:0] vec_tset;
    logic [NP-1:0] cmp_hi, cmp_lo, src_data;
    logic          src_ready, vec_out_valid, cap_valid, status_valid, status_match;
    logic          any_fail, err_repeat, err_illegal, err_underflow;
    logic [NP-1:0] drv_en, drv_data, pin_fail, cap_data, status_fail, fail_sticky;
    logic [TW-1:0] tset_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pve_engine #(.NPINS(NP), .TSET_W(TW), .LATENCY(LAT)) i_pve_engine (
        .clk(clk), .rst_n(rst_n), .clr(clr), .vec_valid(vec_valid),
        .vec_codes(vec_codes), .vec_tset(vec_tset), .cmp_hi(cmp_hi),
        .cmp_lo(cmp_lo), .cap_en(cap_en), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data), .drv_en(drv_en),
        .drv_data(drv_data), .tset_out(tset_out), .vec_out_valid(vec_out_valid),
        .pin_fail(pin_fail), .cap_valid(cap_valid), .cap_data(cap_data),
        .status_valid(status_valid), .status_match(status_match),
        .status_fail(status_fail), .fail_sticky(fail_sticky),
        .any_fail(any_fail), .err_repeat(err_repeat),
        .err_illegal(err_illegal), .err_underflow(err_underflow)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one vector at a falling edge and wait until the next one.
    task automatic vec(input logic [15:0] codes, input logic [4:0] ts,
                       input logic [3:0] hi, input logic [3:0] lo,
                       input logic [3:0] sd, input logic sv, input logic ce);
        vec_valid = 1'b1; vec_codes = codes; vec_tset = ts;
        cmp_hi = hi; cmp_lo = lo; src_data = sd; src_valid = sv; cap_en = ce;
        clr = 1'b0;
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic idle(input int n, input logic c);
        vec_valid = 1'b0; clr = c; cmp_hi = '0; cmp_lo = '0; src_valid = 1'b0;
        repeat (n) @(negedge clk);
        clr = 1'b0;
    endtask

    function automatic logic exp_fail(input int c, input logic hi, input logic lo,
                                      input logic sb);
        case (c)
            2: return !(lo && !hi);
            3: return !(hi && !lo);
            5: return hi || lo;
            6: return !(hi ^ lo);
            8: return sb ? !(hi && !lo) : !(lo && !hi);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] one_pin(input int p, input logic [3:0] c);
        logic [15:0] v;
        v = 16'h4444;
        v[p*4 +: 4] = c;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; vec_valid = 1'b0; vec_codes = 16'h4444;
        vec_tset = '0; cmp_hi = '0; cmp_lo = '0; cap_en = 1'b0;
        src_valid = 1'b0; src_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R11", "reset sticky", {28'd0, fail_sticky}, 32'd0);
        check("R11", "reset errors", {29'd0, err_repeat, err_illegal, err_underflow}, 32'd0);
        check("R9", "reset status", {31'd0, status_valid}, 32'd0);
        check("R1", "reset drive", {28'd0, drv_en}, 32'd0);

        // First-vector repeat on pin 0 and on the time set
        vec(one_pin(0, 4'h9), 5'd31, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0);
        check("R7", "first repeat error", {31'd0, err_repeat}, 32'd1);
        check("R7", "first repeat inert", {24'd0, drv_en, pin_fail}, 32'd0);
        check("R8", "first tset repeat", {27'd0, tset_out}, 32'd0);
        idle(1, 1'b1);
        check("R11", "clear errors", {31'd0, err_repeat}, 32'd0);

        // Repeat chains for the state and the time set
        vec(one_pin(0, 4'h3), 5'd5, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0);
        check("R2", "H with low reading fails", {28'd0, pin_fail}, 32'd1);
        vec(one_pin(0, 4'h9), 5'd31, 4'h0, 4'h1, 4'h0, 1'b1, 1'b0);
        check("R7", "repeat H fails on low", {28'd0, pin_fail}, 32'd1);
        check("R8", "tset repeat", {27'd0, tset_out}, 32'd5);
        vec(one_pin(0, 4'h9), 5'd31, 4'h1, 4'h0, 4'h0, 1'b1, 1'b0);
        check("R7", "repeat H passes on high", {28'd0, pin_fail}, 32'd0);
        check("R8", "tset repeat again", {27'd0, tset_out}, 32'd5);
        vec(one_pin(0, 4'h1), 5'd30, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
        vec(one_pin(0, 4'h9), 5'd31, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
        check("R7", "repeat drive one", {24'd0, drv_en, drv_data}, 32'h11);
        check("R8", "tset 30 kept", {27'd0, tset_out}, 32'd30);
        check("R7", "no new repeat error", {31'd0, err_repeat}, 32'd0);

        // Sweep: each legal code on each pin, all comparator readings, both source bits
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 9; c++) begin
                for (int hl = 0; hl < 4; hl++) begin
                    for (int sb = 0; sb < 2; sb++) begin
                        logic h, l, ef, ee;
                        logic [3:0] m;
                        h = hl[1]; l = hl[0];
                        m = 4'b0001 << p;
                        vec(one_pin(p, c[3:0]), TW'(c), h ? m : 4'h0, l ? m : 4'h0,
                            sb ? m : 4'h0, 1'b1, 1'b0);
                        ef = exp_fail(c, h, l, sb[0]);
                        ee = (c == 0) || (c == 1) || (c == 7);
                        check(c == 4 ? "R3" : (c < 2 ? "R1" : (c < 4 ? "R2" :
                              (c == 5 ? "R4" : (c == 6 ? "R5" : "R6")))),
                              "sweep fail", {28'd0, pin_fail}, {28'd0, ef ? m : 4'h0});
                        check(c < 2 ? "R1" : "R6", "sweep drive",
                              {24'd0, drv_en, drv_data},
                              {24'd0, ee ? m : 4'h0,
                               ((c == 1) || (c == 7 && sb == 1)) ? m : 4'h0});
                    end
                end
            end
        end

        // Illegal codes act as masked and raise the flag
        for (int c = 10; c < 16; c++) begin
            idle(1, 1'b1);
            vec(one_pin(2, c[3:0]), 5'd1, 4'h4, 4'h0, 4'h0, 1'b1, 1'b0);
            check("R10", "illegal flag", {31'd0, err_illegal}, 32'd1);
            check("R10", "illegal inert", {24'd0, drv_en, pin_fail}, 32'd0);
        end
        idle(1, 1'b1);
        vec(one_pin(2, 4'h9), 5'd1, 4'hF, 4'hF, 4'h0, 1'b1, 1'b0);
        check("R10", "repeat after illegal masked", {28'd0, pin_fail}, 32'd0);
        check("R7", "repeat after illegal no error", {31'd0, err_repeat}, 32'd0);

        // Source handshake and underflow
        idle(1, 1'b1);
        vec_valid = 1'b1; vec_codes = 16'h4444; src_valid = 1'b1; #1;
        check("R6", "no source request", {31'd0, src_ready}, 32'd0);
        vec_codes = one_pin(0, 4'h7); src_valid = 1'b0; #1;
        check("R12", "source request", {31'd0, src_ready}, 32'd1);
        @(negedge clk);
        vec_valid = 1'b0;
        check("R12", "underflow flag", {31'd0, err_underflow}, 32'd1);
        check("R12", "underflow masked", {28'd0, drv_en}, 32'd0);
        vec(one_pin(0, 4'h8), 5'd1, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0);
        check("R12", "expect underflow masked", {28'd0, pin_fail}, 32'd0);
        vec(one_pin(0, 4'h7), 5'd1, 4'h0, 4'h0, 4'h1, 1'b1, 1'b0);
        check("R6", "source drive", {24'd0, drv_en, drv_data}, 32'h11);
        check("R12", "underflow sticky", {31'd0, err_underflow}, 32'd1);

        // Capture of either-valid pins
        vec(16'h6444, 5'd1, 4'h8, 4'h0, 4'h0, 1'b1, 1'b1);
        check("R5", "capture valid", {31'd0, cap_valid}, 32'd1);
        check("R5", "capture data high", {28'd0, cap_data}, 32'h8);
        vec(16'h6444, 5'd1, 4'h0, 4'h8, 4'h0, 1'b1, 1'b1);
        check("R5", "capture data low", {27'd0, cap_valid, cap_data}, 32'h10);
        vec(16'h6444, 5'd1, 4'h8, 4'h0, 4'h0, 1'b1, 1'b0);
        check("R5", "capture disabled", {31'd0, cap_valid}, 32'd0);

        // Sticky record and clear
        idle(1, 1'b1);
        vec(one_pin(2, 4'h2), 5'd1, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
        vec(one_pin(2, 4'h2), 5'd1, 4'h0, 4'h4, 4'h0, 1'b1, 1'b0);
        check("R11", "pass after fail", {28'd0, pin_fail}, 32'd0);
        check("R11", "sticky held", {27'd0, any_fail, fail_sticky}, 32'h14);
        idle(1, 1'b1);
        check("R11", "sticky cleared", {27'd0, any_fail, fail_sticky}, 32'd0);

        // Status delay: exact latency of fail and match records
        idle(LAT + 5, 1'b0);
        check("R9", "status idle", {31'd0, status_valid}, 32'd0);
        vec(one_pin(1, 4'h3), 5'd1, 4'h0, 4'h2, 4'h0, 1'b1, 1'b0);
        check("R9", "immediate fail", {28'd0, pin_fail}, 32'h2);
        idle(LAT - 1, 1'b0);
        check("R9", "status not early", {31'd0, status_valid}, 32'd0);
        idle(1, 1'b0);
        check("R9", "status fail record", {26'd0, status_valid, status_match, status_fail},
              32'h22);
        idle(1, 1'b0);
        check("R9", "status one cycle", {31'd0, status_valid}, 32'd0);
        vec(one_pin(1, 4'h3), 5'd1, 4'h2, 4'h0, 4'h0, 1'b1, 1'b0);
        idle(LAT, 1'b0);
        check("R9", "status match record", {26'd0, status_valid, status_match, status_fail},
              32'h30);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule